// File: doc/BRIEF.md
# Clock Generator Test-Mode Controller

This block holds the control and identification bytes of a clock generator and decides what its clock outputs do. It has three modes: normal running, all outputs tri-stated, or outputs carrying a divided reference. Three frequency-select pins are sampled while power-on reset is held. A separate digital flag comes from the multi-level detector on one of those pins. If that flag is sampled high, the part enters test at power-up. Test can also be entered later from software through a control bit. Either way, the part then stays in test until the next power-on reset.

A simple register port reaches two byte addresses. The control byte (address 6) carries:
- the test controls;
- the reference drive strength;
- the PCI/SRC clock halt;
- the latched frequency-select values, read-only.

The identification byte (address 7) is fixed. When test was entered by the hardware flag, the live level of the frequency-select B pin (`fs_pins[1]`) can force the reference output. When test was entered by software, only a register bit chooses the outcome.

Top module: `clkgen_testctl`

## Requirements
- R1: After reset, the control byte reads `{0,0,0,1,1,fs_latched[2:0]}`, `ref_strength_2x` is 1 and `pci_src_halt` is 0. `out_mode` is normal (2'b00) unless the hardware flag was latched high.
- R2: While `rst` is high, `fs_pins[2:0]` and `test_sel_flag` are captured every cycle. After reset they hold, and control-byte bits 2..0 read FS_C, FS_B, FS_A. Pin changes after reset do not alter the readback.
- R3: `out_mode` is normal (2'b00) only when the latched flag is 0 and control bit 6 has not been written 1 since reset.
- R4: With the hardware flag latched high, `out_mode` is reference (2'b10) if live `fs_pins[1]` is 1 or control bit 7 is 1. Otherwise it is tri-state (2'b01).
- R5: With test entered by software only, control bit 7 alone decides: 1 gives reference (2'b10) and 0 gives tri-state (2'b01). Live `fs_pins[1]` has no effect.
- R6: Writing 0 to control bit 6 does not return the outputs to normal; the bit still reads back the written value. Only `rst` restores normal mode.
- R7: Control bit 4 drives `ref_strength_2x` (1 = 2X, 0 = 1X). Control bit 3 set to 0 asserts `pci_src_halt`.
- R8: Address 7 always reads 8'h11 (revision nibble 1 high, vendor nibble 1 low). Writes to it change nothing.
- R9: Control bit 5 reads 0. Writes to bits 5 and 2..0 are ignored. Reads of any address other than 6 and 7 return 8'h00, and writes to them change nothing.
- R10: `reg_rdata` presents the addressed byte on the cycle after `reg_rd_en`. `out_mode` reflects a pin or register change one clock edge after that change is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| fs_pins | input | 3 | Frequency-select pins {C,B,A}; bit 1 is also the live test-mode level |
| test_sel_flag | input | 1 | Digital test-select result from the pin-level detector |
| reg_addr | input | 4 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| out_mode | output | 2 | 00 normal, 01 tri-state, 10 divided reference |
| ref_strength_2x | output | 1 | Reference drive strength select |
| pci_src_halt | output | 1 | Stops PCI and SRC clocks |

## Verification
The bench toggles the live select-B pin while in software-entered test. A design that consulted the pin there would wrongly flip to reference output. It clears the entry bit after entering test, so a non-sticky design would fall back to normal. It changes the frequency-select pins after reset, which a design that keeps sampling them would expose as a changing readback. It also writes all-ones to the ID byte, to the reserved bit and to unused addresses. A design that stores those writes would return wrong ID, bit 5 or zero-address data.

// File: rtl/clkgen_testctl_pkg.sv
package clkgen_testctl_pkg;

  typedef enum logic [1:0] {
    OMODE_NORMAL = 2'b00,
    OMODE_HIZ    = 2'b01,
    OMODE_REF    = 2'b10
  } omode_e;

  localparam logic [7:0] CTL_RESET  = 8'h18;
  localparam logic [7:0] CTL_WMASK  = 8'hD8;
  localparam int         BIT_REFSEL = 7;
  localparam int         BIT_ENTRY  = 6;
  localparam int         BIT_STRENG = 4;
  localparam int         BIT_RUN    = 3;

endpackage

// File: rtl/clkgen_strap_latch.sv
module clkgen_strap_latch #(
  parameter int FS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FS_W-1:0] fs_pins,
  input  logic            test_sel_flag,
  output logic [FS_W-1:0] fs_q,
  output logic            strap_q
);

  for (genvar i = 0; i < FS_W; i++) begin : g_fs
    always_ff @(posedge clk) begin
      if (rst) fs_q[i] <= fs_pins[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strap_q <= test_sel_flag;
  end

  // R2
  fs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(fs_q) && $stable(strap_q));

endmodule

// File: rtl/clkgen_ctl_regs.sv
module clkgen_ctl_regs
  import clkgen_testctl_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter int         FS_W     = 3,
  parameter int         CTL_ADDR = 6,
  parameter int         ID_ADDR  = 7,
  parameter logic [3:0] REV_ID   = 4'h1,
  parameter logic [3:0] VEND_ID  = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd_en,
  input  logic [FS_W-1:0]   fs_q,
  output logic [7:0]        reg_rdata,
  output logic              ctl_refsel,
  output logic              ctl_entry,
  output logic              strength_2x,
  output logic              halt
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(ID_ADDR);
  localparam logic [7:0]        ID_BYTE = {REV_ID, VEND_ID};

  logic [7:0] ctl_q;
  logic [7:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
    end else if (reg_wr_en && reg_addr == A_CTL) begin
      ctl_q <= (ctl_q & ~CTL_WMASK) | (reg_wdata & CTL_WMASK);
    end
  end

  always_comb begin
    if (reg_addr == A_CTL)     rd_mux = (ctl_q & CTL_WMASK) | 8'(fs_q);
    else if (reg_addr == A_ID) rd_mux = ID_BYTE;
    else                       rd_mux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strength_2x <= CTL_RESET[BIT_STRENG];
      halt        <= ~CTL_RESET[BIT_RUN];
    end else begin
      strength_2x <= ctl_q[BIT_STRENG];
      halt        <= ~ctl_q[BIT_RUN];
    end
  end

  assign ctl_refsel = ctl_q[BIT_REFSEL];
  assign ctl_entry  = ctl_q[BIT_ENTRY];

  // R8
  id_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd_en) && $past(reg_addr) == A_ID |-> reg_rdata == ID_BYTE);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd_en) && $past(reg_addr) != A_ID && $past(reg_addr) != A_CTL
      |-> reg_rdata == 8'h00);

  // R9
  resv_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd_en) && $past(reg_addr) == A_CTL |-> reg_rdata[5] == 1'b0);

endmodule

// File: rtl/clkgen_mode_decode.sv
module clkgen_mode_decode
  import clkgen_testctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_q,
  input  logic       tmode_live,
  input  logic       ctl_refsel,
  input  logic       ctl_entry,
  output logic [1:0] mode
);

  logic   sw_sticky_q;
  logic   sw_seen;
  omode_e mode_d;
  omode_e mode_q;

  assign sw_seen = ctl_entry | sw_sticky_q;

  always_ff @(posedge clk) begin
    if (rst) sw_sticky_q <= 1'b0;
    else     sw_sticky_q <= sw_sticky_q | ctl_entry;
  end

  always_comb begin
    if (strap_q)      mode_d = (tmode_live | ctl_refsel) ? OMODE_REF : OMODE_HIZ;
    else if (sw_seen) mode_d = ctl_refsel ? OMODE_REF : OMODE_HIZ;
    else              mode_d = OMODE_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= OMODE_NORMAL;
    else     mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R6
  sticky_test_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q != OMODE_NORMAL |=> mode_q != OMODE_NORMAL);

  // R4
  hw_pin_ref_chk: assert property (@(posedge clk) disable iff (rst)
    strap_q && tmode_live |=> mode_q == OMODE_REF);

  // R5
  sw_pin_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !strap_q && sw_seen && !ctl_refsel |=> mode_q == OMODE_HIZ);

  // R3
  normal_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strap_q && !sw_seen |=> mode_q == OMODE_NORMAL);

endmodule

// File: rtl/clkgen_testctl.sv
module clkgen_testctl #(
  parameter int         ADDR_W    = 4,
  parameter int         FS_W      = 3,
  parameter int         TMODE_BIT = 1,
  parameter int         CTL_ADDR  = 6,
  parameter int         ID_ADDR   = 7,
  parameter logic [3:0] REV_ID    = 4'h1,
  parameter logic [3:0] VEND_ID   = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FS_W-1:0]   fs_pins,
  input  logic              test_sel_flag,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd_en,
  output logic [7:0]        reg_rdata,
  output logic [1:0]        out_mode,
  output logic              ref_strength_2x,
  output logic              pci_src_halt
);

  logic [FS_W-1:0] fs_q;
  logic            strap_q;
  logic            ctl_refsel;
  logic            ctl_entry;

  clkgen_strap_latch #(.FS_W(FS_W)) u_strap (
    .clk           (clk),
    .rst           (rst),
    .fs_pins       (fs_pins),
    .test_sel_flag (test_sel_flag),
    .fs_q          (fs_q),
    .strap_q       (strap_q)
  );

  clkgen_ctl_regs #(
    .ADDR_W   (ADDR_W),
    .FS_W     (FS_W),
    .CTL_ADDR (CTL_ADDR),
    .ID_ADDR  (ID_ADDR),
    .REV_ID   (REV_ID),
    .VEND_ID  (VEND_ID)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rd_en   (reg_rd_en),
    .fs_q        (fs_q),
    .reg_rdata   (reg_rdata),
    .ctl_refsel  (ctl_refsel),
    .ctl_entry   (ctl_entry),
    .strength_2x (ref_strength_2x),
    .halt        (pci_src_halt)
  );

  clkgen_mode_decode u_mode (
    .clk        (clk),
    .rst        (rst),
    .strap_q    (strap_q),
    .tmode_live (fs_pins[TMODE_BIT]),
    .ctl_refsel (ctl_refsel),
    .ctl_entry  (ctl_entry),
    .mode       (out_mode)
  );

endmodule

// File: tb/sim_clkgen_testctl.sv
`timescale 1ns/1ps
module sim_clkgen_testctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] fs_pins = 3'b000;
  logic       test_sel_flag = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rd_en = 1'b0;
  logic [7:0] reg_rdata;
  logic [1:0] out_mode;
  logic       ref_strength_2x;
  logic       pci_src_halt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [2:0] m_fs;
  logic       m_strap, m_b7, m_b6, m_b4, m_b3, m_sw;

  always #2.5 clk = ~clk;

  clkgen_testctl u0 (
    .clk(clk), .rst(rst), .fs_pins(fs_pins), .test_sel_flag(test_sel_flag),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .out_mode(out_mode),
    .ref_strength_2x(ref_strength_2x), .pci_src_halt(pci_src_halt)
  );

  function automatic logic [1:0] exp_mode();
    if (m_strap) return (fs_pins[1] | m_b7) ? 2'b10 : 2'b01;
    else if (m_sw) return m_b7 ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] a);
    if (a == 4'd6) return {m_b7, m_b6, 1'b0, m_b4, m_b3, m_fs};
    if (a == 4'd7) return 8'h11;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_outs(string req);
    chk(req, {6'd0, out_mode}, {6'd0, exp_mode()});
    chk({req, "/R7"}, {6'd0, ref_strength_2x, pci_src_halt}, {6'd0, m_b4, ~m_b3});
  endtask

  task automatic do_reset(logic [2:0] fs, logic sel);
    rst = 1'b1; fs_pins = fs; test_sel_flag = sel;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_fs = fs; m_strap = sel; m_b7 = 0; m_b6 = 0; m_b4 = 1; m_b3 = 1; m_sw = 0;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 4'd6) begin
      m_b7 = d[7]; m_b6 = d[6]; m_b4 = d[4]; m_b3 = d[3];
      if (d[6]) m_sw = 1'b1;
    end
  endtask

  task automatic rd(string req, logic [3:0] a);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk(req, reg_rdata, exp_read(a));
  endtask

  task automatic set_pins(logic [2:0] p);
    fs_pins = p;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    @(negedge clk);

    // R1 R2: reset state with straps 101, no hardware test
    do_reset(3'b101, 1'b0);
    chk_outs("R1 reset outputs");
    rd("R1 ctl default", 4'd6);
    rd("R8 id byte", 4'd7);
    rd("R9 unmapped read", 4'd3);

    // R2: later pin changes do not move latched readback
    set_pins(3'b010);
    rd("R2 latch holds", 4'd6);
    chk_outs("R3 still normal");

    // R8 R9: writes to id, unmapped, reserved bits
    wr(4'd7, 8'hFF);
    rd("R8 id after write", 4'd7);
    wr(4'd2, 8'hFF);
    rd("R9 unmapped after write", 4'd2);
    wr(4'd6, 8'h27);
    rd("R9 reserved bits ignored", 4'd6);
    @(negedge clk);
    chk_outs("R7 strength 1x and halt");

    // R10 R5: software entry latency, pin ignored
    wr(4'd6, 8'h58);
    chk("R10 mode not yet updated", {6'd0, out_mode}, 8'h00);
    @(negedge clk);
    chk_outs("R5 sw entry hiz");
    set_pins(3'b111);
    chk_outs("R5 pin ignored high");
    set_pins(3'b000);
    chk_outs("R5 pin ignored low");
    wr(4'd6, 8'hD8); @(negedge clk);
    chk_outs("R5 sw ref");

    // R6: clearing entry bit is sticky
    wr(4'd6, 8'h98); @(negedge clk);
    chk_outs("R6 sticky ref");
    rd("R6 bit readback", 4'd6);
    wr(4'd6, 8'h18); @(negedge clk);
    chk_outs("R6 sticky hiz");

    // R4: hardware strap entry
    do_reset(3'b000, 1'b1);
    chk_outs("R4 strap hiz");
    set_pins(3'b010);
    chk_outs("R4 live pin ref");
    set_pins(3'b000);
    chk_outs("R4 live pin back hiz");
    wr(4'd6, 8'h98); @(negedge clk);
    chk_outs("R4 refsel bit ref");
    wr(4'd6, 8'h18); @(negedge clk);
    chk_outs("R4 refsel cleared hiz");

    // R6: reset is the only way out
    do_reset(3'b011, 1'b0);
    chk_outs("R6 reset exits test");
    rd("R2 new latch value", 4'd6);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 99);
      if (op < 3) begin
        do_reset(3'($urandom), ($urandom_range(0, 3) == 0));
        chk_outs("R1 random reset");
      end else if (op < 45) begin
        logic [3:0] a;
        a = ($urandom_range(0, 2) != 0) ? 4'd6 : 4'($urandom);
        wr(a, 8'($urandom));
        @(negedge clk);
        chk_outs("R3 random write");
      end else if (op < 70) begin
        set_pins(3'($urandom));
        chk_outs("R4 random pins");
      end else begin
        rd("R9 random read", ($urandom_range(0, 1) != 0) ? 4'd6 : 4'($urandom));
      end
    end

    summary();
  end

endmodule